// File: doc/BRIEF.md
# Vector Integer Reduction Unit

This block folds the active elements of a vector operand into one scalar. A job starts with a one-cycle `start` pulse carrying the operation code, element width, register-group multiplier, source register number, vector length, start index, mask enable and mask. The accumulator is loaded with the scalar seed, and element zero of the destination receives the final value. Source elements then arrive one per accepted beat on a valid/ready stream. Eight single-width operations share one datapath with the two widening sums (signed and unsigned).

Legality is decided in the cycle `start` is sampled, before any element is taken. An illegal job ends on the next cycle with `done` and `illegal` high, no write, and `elem_ready` never asserted. The element stream transfers a beat on each rising edge where `elem_valid` and `elem_ready` are both high. `elem_ready` is high only while a job is collecting elements, and it drops in the cycle after the last of the `vl` elements is accepted. The producer may hold back data at any time by keeping `elem_valid` low. The unit never takes more than `vl` elements, and `start` is ignored while a job is collecting.

Top module: `vred_unit`

## Requirements
- R1: An accepted `start` with a nonzero `vstart` makes `done` and `illegal` high for one cycle on the next cycle. `wr_en` stays low, `result` keeps its value and no element is requested.
- R2: A legal job with `vl` = 0 gives `done` high on the next cycle with `wr_en` and `illegal` low, and `result` is unchanged.
- R3: Sum (code 0) adds with wraparound at the element width. Widths are coded `sew` 0..3 = 8, 16, 32, 64 bits. `result` holds the value zero-extended from that width.
- R4: AND (1), OR (2) and XOR (3) combine bitwise over the element width.
- R5: Unsigned minimum (4) and unsigned maximum (6) compare the seed and the elements with bits above the element width ignored. An element replaces the accumulator only when strictly smaller or strictly larger, respectively.
- R6: Signed minimum (5) and signed maximum (7) compare values sign-extended from the element width, with the same strict replacement rule.
- R7: Unsigned widening sum (8) and signed widening sum (9) use a seed of twice the element width as given. Each element is zero-extended (8) or sign-extended (9) to double width before it is added, and the result is zero-extended from double width.
- R8: With `mask_en` = 1, element i (stream order from 0) whose `mask` bit i is 0 is consumed but not combined.
- R9: Exactly `vl` elements are accepted. `elem_ready` is low outside a collecting job, and after `done` further offered elements are neither taken nor change `result`.
- R10: The last accepted element gives `done` and `wr_en` high together on the next cycle, with the final value on `result`. `result` changes only while `wr_en` is high.
- R11: These are also illegal, with R1 behaviour: `cfg_ok` = 0, `lmul` code 4, an opcode above 9, `vl` above the element capacity, a widening sum whose doubled width exceeds `MAX_W`, and a `vs2_idx` that is not a multiple of the group size. The group size is 1, 2, 4 or 8 for `lmul` codes 0..3 and 1 for codes 5..7.
- R12: During reset and after it, `done`, `wr_en`, `illegal` and `elem_ready` are low and `result` is zero.
- R13: A `start` raised while a job is collecting is ignored. A `start` sampled in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job request pulse, sampled when idle |
| op | input | 4 | Operation code 0..9 |
| sew | input | 2 | Element width code (8<<sew bits) |
| lmul | input | 3 | Register-group multiplier code |
| cfg_ok | input | 1 | Vector type valid and vector unit enabled |
| vs2_idx | input | $clog2(VREG_N) | Source register number |
| vl | input | $clog2(MAX_ELEMS+1) | Number of elements |
| vstart | input | $clog2(MAX_ELEMS+1) | Start index, must be zero |
| mask_en | input | 1 | Enable element masking |
| mask | input | MAX_ELEMS | Per-element enable bits |
| seed | input | MAX_W | Scalar initial accumulator value |
| elem_valid | input | 1 | Element beat offered |
| elem_ready | output | 1 | Element beat accepted when valid |
| elem_data | input | MAX_W | Element value, low bits significant |
| done | output | 1 | Job finished, one-cycle pulse |
| wr_en | output | 1 | Destination write strobe |
| illegal | output | 1 | Illegal-instruction indication |
| result | output | MAX_W | Reduced value |

## Verification
Two things can fall in the same cycle: the completion of one job, with `done` and possibly `wr_en` high, and the sampling of a new `start`. The bench raises `start` in the cycle where `done` of a finished sum is visible. It then judges two points: the earlier result stays on `result`, and the new, deliberately illegal job reports `done` with `illegal` exactly one cycle later. It also raises `start` while elements are still being taken. There it checks that the running sum completes with the right value and that no extra `done` follows.

// File: rtl/vred_pkg.sv
package vred_pkg;

  typedef enum logic [3:0] {
    OP_SUM   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_MINU  = 4'd4,
    OP_MIN   = 4'd5,
    OP_MAXU  = 4'd6,
    OP_MAX   = 4'd7,
    OP_WSUMU = 4'd8,
    OP_WSUM  = 4'd9
  } red_op_e;

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } red_state_e;

  function automatic logic op_is_widen(logic [3:0] code);
    return (code == OP_WSUMU) || (code == OP_WSUM);
  endfunction

endpackage

// File: rtl/vred_legal.sv
module vred_legal #(
  parameter int MAX_W     = 64,
  parameter int MAX_ELEMS = 64,
  parameter int VL_W      = 7,
  parameter int RI_W      = 5
) (
  input  logic [3:0]      op,
  input  logic [1:0]      sew,
  input  logic [2:0]      lmul,
  input  logic            cfg_ok,
  input  logic [RI_W-1:0] vs2_idx,
  input  logic [VL_W-1:0] vl,
  input  logic [VL_W-1:0] vstart,
  output logic            bad
);
  import vred_pkg::*;

  logic [RI_W-1:0] grp_mask;
  logic            misalign;
  logic            width_bad;
  logic            widen_bad;

  always_comb begin
    grp_mask  = lmul[2] ? '0 : RI_W'((32'd1 << lmul[1:0]) - 32'd1);
    misalign  = |(vs2_idx & grp_mask);
    width_bad = (32'd8 << sew) > 32'(MAX_W);
    widen_bad = op_is_widen(op) && ((32'd16 << sew) > 32'(MAX_W));
    bad = !cfg_ok
       || (vstart != '0)
       || (op > 4'd9)
       || (lmul == 3'd4)
       || (vl > VL_W'(MAX_ELEMS))
       || width_bad
       || widen_bad
       || misalign;
  end

endmodule

// File: rtl/vred_alu.sv
module vred_alu #(
  parameter int MAX_W = 64
) (
  input  vred_pkg::red_op_e op,
  input  logic [1:0]        sew,
  input  logic              take,
  input  logic [MAX_W-1:0]  acc,
  input  logic [MAX_W-1:0]  elem,
  output logic [MAX_W-1:0]  nxt
);
  import vred_pkg::*;

  function automatic logic [MAX_W-1:0] low_ones(int n);
    if (n >= MAX_W) return '1;
    return ~({MAX_W{1'b1}} << n);
  endfunction

  function automatic logic [MAX_W-1:0] sx(logic [MAX_W-1:0] x, int n);
    logic [MAX_W-1:0] m;
    m = low_ones(n);
    return x[n-1] ? (x | ~m) : (x & m);
  endfunction

  int               w;
  int               wo;
  logic [MAX_W-1:0] m_in;
  logic [MAX_W-1:0] m_out;
  logic [MAX_W-1:0] ea, aa;
  logic [MAX_W-1:0] es, as;
  logic [MAX_W-1:0] comb_v;

  always_comb begin
    w     = 8 << sew;
    wo    = op_is_widen(op) ? 2 * w : w;
    m_in  = low_ones(w);
    m_out = low_ones(wo);
    ea    = elem & m_in;
    aa    = acc & m_in;
    es    = sx(elem, w);
    as    = sx(acc, w);
    unique case (op)
      OP_SUM:   comb_v = acc + elem;
      OP_AND:   comb_v = acc & elem;
      OP_OR:    comb_v = acc | elem;
      OP_XOR:   comb_v = acc ^ elem;
      OP_MINU:  comb_v = (ea < aa) ? elem : acc;
      OP_MAXU:  comb_v = (ea > aa) ? elem : acc;
      OP_MIN:   comb_v = ($signed(es) < $signed(as)) ? elem : acc;
      OP_MAX:   comb_v = ($signed(es) > $signed(as)) ? elem : acc;
      OP_WSUMU: comb_v = acc + ea;
      OP_WSUM:  comb_v = acc + es;
      default:  comb_v = acc;
    endcase
    nxt = (take ? comb_v : acc) & m_out;
  end

endmodule

// File: rtl/vred_unit.sv
module vred_unit #(
  parameter int MAX_W     = 64,
  parameter int MAX_ELEMS = 64,
  parameter int VREG_N    = 32,
  localparam int VL_W     = $clog2(MAX_ELEMS + 1),
  localparam int IX_W     = $clog2(MAX_ELEMS),
  localparam int RI_W     = $clog2(VREG_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [3:0]           op,
  input  logic [1:0]           sew,
  input  logic [2:0]           lmul,
  input  logic                 cfg_ok,
  input  logic [RI_W-1:0]      vs2_idx,
  input  logic [VL_W-1:0]      vl,
  input  logic [VL_W-1:0]      vstart,
  input  logic                 mask_en,
  input  logic [MAX_ELEMS-1:0] mask,
  input  logic [MAX_W-1:0]     seed,
  input  logic                 elem_valid,
  output logic                 elem_ready,
  input  logic [MAX_W-1:0]     elem_data,
  output logic                 done,
  output logic                 wr_en,
  output logic                 illegal,
  output logic [MAX_W-1:0]     result
);
  import vred_pkg::*;

  red_state_e           state;
  red_op_e              op_q;
  logic [1:0]           sew_q;
  logic [VL_W-1:0]      vl_q;
  logic [VL_W-1:0]      idx;
  logic                 men_q;
  logic [MAX_ELEMS-1:0] mask_q;
  logic [MAX_W-1:0]     acc;
  logic [MAX_W-1:0]     nxt;
  logic                 bad;
  logic                 take;
  logic                 last;

  vred_legal #(
    .MAX_W(MAX_W), .MAX_ELEMS(MAX_ELEMS), .VL_W(VL_W), .RI_W(RI_W)
  ) u_legal (
    .op(op), .sew(sew), .lmul(lmul), .cfg_ok(cfg_ok),
    .vs2_idx(vs2_idx), .vl(vl), .vstart(vstart), .bad(bad)
  );

  assign take = !men_q || mask_q[idx[IX_W-1:0]];
  assign last = (VL_W'(idx + 1'b1) == vl_q);

  vred_alu #(.MAX_W(MAX_W)) u_alu (
    .op(op_q), .sew(sew_q), .take(take),
    .acc(acc), .elem(elem_data), .nxt(nxt)
  );

  assign elem_ready = (state == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_SUM;
      sew_q   <= '0;
      vl_q    <= '0;
      idx     <= '0;
      men_q   <= 1'b0;
      mask_q  <= '0;
      acc     <= '0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
    end else begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q   <= red_op_e'(op);
            sew_q  <= sew;
            vl_q   <= vl;
            men_q  <= mask_en;
            mask_q <= mask;
            acc    <= seed;
            idx    <= '0;
            if (bad) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else if (vl == '0) begin
              done <= 1'b1;
            end else begin
              state <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (elem_valid) begin
            acc <= nxt;
            idx <= idx + 1'b1;
            if (last) begin
              state  <= ST_IDLE;
              done   <= 1'b1;
              wr_en  <= 1'b1;
              result <= nxt;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vred_sva.sv
module vred_sva #(
  parameter int MAX_W = 64,
  parameter int VL_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VL_W-1:0]  vstart,
  input logic             elem_valid,
  input logic             elem_ready,
  input logic             done,
  input logic             wr_en,
  input logic             illegal,
  input logic [MAX_W-1:0] result
);

  // R1
  p_illegal_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr_en));

  // R10
  p_write_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && !illegal));

  // R10
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable(result));

  // R9
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(elem_ready && elem_valid) || $past(start && !elem_ready)));

  // R9
  p_no_ready_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_ready);

  // R1
  p_vstart_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !elem_ready && (vstart != '0)) |=> (illegal && done));

endmodule

bind vred_unit vred_sva #(.MAX_W(MAX_W), .VL_W(VL_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .vstart(vstart),
  .elem_valid(elem_valid), .elem_ready(elem_ready), .done(done),
  .wr_en(wr_en), .illegal(illegal), .result(result)
);

// File: tb/sim_vred_unit.sv
module sim_vred_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  sew = '0;
  logic [2:0]  lmul = '0;
  logic        cfg_ok = 1'b1;
  logic [4:0]  vs2_idx = '0;
  logic [6:0]  vl = '0;
  logic [6:0]  vstart = '0;
  logic        mask_en = 1'b0;
  logic [63:0] mask = '0;
  logic [63:0] seed = '0;
  logic        elem_valid = 1'b0;
  logic        elem_ready;
  logic [63:0] elem_data = '0;
  logic        done, wr_en, illegal;
  logic [63:0] result;

  vred_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sew(sew), .lmul(lmul),
    .cfg_ok(cfg_ok), .vs2_idx(vs2_idx), .vl(vl), .vstart(vstart),
    .mask_en(mask_en), .mask(mask), .seed(seed), .elem_valid(elem_valid),
    .elem_ready(elem_ready), .elem_data(elem_data), .done(done),
    .wr_en(wr_en), .illegal(illegal), .result(result)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sew;
    logic [6:0]  vl;
    logic        men;
    logic [7:0]  mk;
    logic [63:0] seed;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [63:0] e3;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 2'd0, 7'd4, 1'b0, 8'h00, 64'h10, 64'hF0, 64'h05, 64'h01, 64'h02, 64'h08},
    '{4'd1, 2'd1, 7'd4, 1'b0, 8'h00, 64'hFFFF, 64'hF0F3, 64'h3FFF, 64'hFF31, 64'h1234, 64'h1030},
    '{4'd2, 2'd2, 7'd4, 1'b0, 8'h00, 64'h1, 64'h10, 64'h100, 64'h8000_0000, 64'h0, 64'h8000_0111},
    '{4'd3, 2'd3, 7'd4, 1'b0, 8'h00, 64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 64'h0, 64'h0, 64'hF00F_F00F_F00F_F00F},
    '{4'd4, 2'd0, 7'd4, 1'b0, 8'h00, 64'h80, 64'h7F, 64'h81, 64'h105, 64'h90, 64'h05},
    '{4'd5, 2'd0, 7'd4, 1'b0, 8'h00, 64'h05, 64'h7F, 64'h80, 64'hFF, 64'h10, 64'h80},
    '{4'd6, 2'd1, 7'd4, 1'b0, 8'h00, 64'h1, 64'h8000, 64'h7FFF, 64'hFFFF, 64'h1234, 64'hFFFF},
    '{4'd7, 2'd1, 7'd4, 1'b1, 8'h07, 64'hFFFF, 64'h8000, 64'hFFFE, 64'h0002, 64'h7FF0, 64'h0002},
    '{4'd8, 2'd0, 7'd4, 1'b0, 8'h00, 64'h01F0, 64'hFF, 64'h20, 64'h01, 64'h00, 64'h0310},
    '{4'd9, 2'd0, 7'd4, 1'b0, 8'h00, 64'h0010, 64'hFF, 64'h80, 64'h01, 64'h7F, 64'h000F},
    '{4'd9, 2'd2, 7'd4, 1'b0, 8'h00, 64'h0, 64'h8000_0000, 64'hFFFF_FFFF, 64'h0, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF},
    '{4'd0, 2'd0, 7'd4, 1'b1, 8'h0A, 64'h0, 64'h1, 64'h2, 64'h3, 64'h4, 64'h06},
    '{4'd0, 2'd2, 7'd2, 1'b0, 8'h00, 64'hFFFF_FFFF, 64'h1, 64'h5, 64'h0, 64'h0, 64'h05}
  };

  logic [63:0] el [4];
  logic        gap = 1'b0;
  logic        g_done, g_wr, g_ill;
  logic [63:0] g_res;
  int          taken;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect();
    int cyc;
    g_done = 1'b0; g_wr = 1'b0; g_ill = 1'b0; g_res = '0;
    taken = 0; cyc = 0;
    while (!g_done && cyc < 300) begin
      if (done) begin
        g_done = 1'b1; g_wr = wr_en; g_ill = illegal; g_res = result;
      end else begin
        if (elem_ready && taken < 4 && !(gap && cyc[0])) begin
          elem_valid = 1'b1;
          elem_data  = el[taken];
          taken++;
        end
        @(negedge clk);
        elem_valid = 1'b0;
        cyc++;
      end
    end
  endtask

  task automatic set_cfg(input logic [3:0] o, input logic [1:0] s, input logic [6:0] n,
                         input logic [63:0] sd);
    op = o; sew = s; vl = n; seed = sd;
    lmul = 3'd0; vs2_idx = '0; cfg_ok = 1'b1; vstart = '0; mask_en = 1'b0; mask = '0;
  endtask

  task automatic expect_illegal(input string tag, input logic [63:0] prev);
    @(negedge clk);
    issue();
    collect();
    chk(g_done && g_ill && !g_wr && g_res == prev && taken == 0, tag, g_res, prev);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [63:0] prev;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!done && !wr_en && !illegal && !elem_ready && result == '0, "R12 reset", {60'd0, done, wr_en, illegal, elem_ready}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !wr_en && !illegal && !elem_ready, "R12 after reset", {61'd0, done, wr_en, illegal}, '0);

    // Table: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      set_cfg(TBL[i].op, TBL[i].sew, TBL[i].vl, TBL[i].seed);
      mask_en = TBL[i].men;
      mask    = {56'd0, TBL[i].mk};
      el[0] = TBL[i].e0; el[1] = TBL[i].e1; el[2] = TBL[i].e2; el[3] = TBL[i].e3;
      gap = i[0];
      @(negedge clk);
      issue();
      collect();
      chk(g_done && g_wr && !g_ill && g_res == TBL[i].exp, $sformatf("R10 table vector %0d (R3-R8 op)", i), g_res, TBL[i].exp);
      chk(taken == int'(TBL[i].vl), "R9 element count", 64'(taken), 64'(TBL[i].vl));
    end
    gap = 1'b0;
    prev = result;

    // R9: nothing taken after done
    elem_valid = 1'b1; elem_data = 64'h77;
    repeat (3) begin
      @(negedge clk);
      chk(!elem_ready && !done && result == prev, "R9 idle stream ignored", result, prev);
    end
    elem_valid = 1'b0;

    // R1: nonzero vstart
    set_cfg(4'd0, 2'd0, 7'd2, 64'h0); vstart = 7'd1;
    expect_illegal("R1 vstart", prev);
    // R11 cases
    set_cfg(4'd0, 2'd0, 7'd2, 64'h0); cfg_ok = 1'b0;
    expect_illegal("R11 cfg_ok", prev);
    set_cfg(4'd0, 2'd0, 7'd2, 64'h0); lmul = 3'd4;
    expect_illegal("R11 lmul reserved", prev);
    set_cfg(4'd12, 2'd0, 7'd2, 64'h0);
    expect_illegal("R11 opcode", prev);
    set_cfg(4'd9, 2'd3, 7'd2, 64'h0);
    expect_illegal("R11 widen width", prev);
    set_cfg(4'd0, 2'd0, 7'd65, 64'h0);
    expect_illegal("R11 vl capacity", prev);
    set_cfg(4'd0, 2'd0, 7'd1, 64'h3); lmul = 3'd2; vs2_idx = 5'd6;
    expect_illegal("R11 misaligned group", prev);

    // R11: aligned group and fractional group are legal
    set_cfg(4'd0, 2'd0, 7'd1, 64'h3); lmul = 3'd2; vs2_idx = 5'd8; el[0] = 64'h4;
    @(negedge clk); issue(); collect();
    chk(g_done && g_wr && !g_ill && g_res == 64'h7, "R11 aligned legal", g_res, 64'h7);
    set_cfg(4'd2, 2'd0, 7'd1, 64'h30); lmul = 3'd7; vs2_idx = 5'd3; el[0] = 64'h05;
    @(negedge clk); issue(); collect();
    chk(g_done && g_wr && !g_ill && g_res == 64'h35, "R11 fractional legal", g_res, 64'h35);
    prev = 64'h35;

    // R2: vl zero
    set_cfg(4'd0, 2'd0, 7'd0, 64'h99);
    @(negedge clk); issue(); collect();
    chk(g_done && !g_wr && !g_ill && g_res == prev && taken == 0, "R2 vl zero", g_res, prev);

    // R13: start while collecting is ignored
    set_cfg(4'd0, 2'd0, 7'd2, 64'h1); el[0] = 64'h2; el[1] = 64'h3;
    @(negedge clk); issue();
    elem_valid = 1'b1; elem_data = el[0];
    @(negedge clk);
    elem_valid = 1'b0;
    op = 4'd1; vstart = 7'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; vstart = '0;
    el[0] = el[1];
    collect();
    chk(g_done && g_wr && !g_ill && g_res == 64'h6, "R13 start ignored while busy", g_res, 64'h6);
    // R13: start accepted in the done cycle
    vstart = 7'd2;
    issue();
    chk(done && illegal && !wr_en && result == 64'h6, "R13 start in done cycle", result, 64'h6);
    vstart = '0;
    @(negedge clk);
    chk(!done && !elem_ready, "R13 no extra done", {62'd0, done, elem_ready}, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule